// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block records the system time at the moment a packet that wants a timestamp starts through the MAC. It has two independent paths, one for transmit and one for receive. Each path holds a single 64-bit stamp, a valid flag and an enable bit. A transmit packet asks for a stamp through one bit of its descriptor command word. A receive packet qualifies through a match signal that comes from the packet filter. The stamp is taken from the free-running time bus in the same cycle as the start-of-frame strobe.

Only one stamp can be held per direction. While a path holds a stamp, every later request on that path is dropped, so a held stamp always belongs to exactly one packet. Software reads the stamp as two 32-bit words. Reading the upper word releases the path, and the path can then capture the next qualifying packet. For each packet the block also reports whether that packet was stamped: a one-cycle pulse for transmit, and a descriptor status flag for receive.

Top module: `ts_capture_latch`

## Requirements
- R1: After reset both enable bits and both valid flags are 0, every control register reads 0, and neither per-packet status output is asserted.
- R2: When the transmit path is enabled and holds no stamp, a `tx_sof` with command bit 19 set (mask 0x00080000) captures `cur_time` from that cycle. One clock later `tx_stamped` pulses high and the transmit valid flag is set.
- R3: A `tx_sof` whose command bit 19 is clear captures nothing, and `tx_stamped` stays 0.
- R4: When the receive path is enabled and holds no stamp, an `rx_sof` with `rx_qual` high captures `cur_time`. One clock later `rx_status` bit 16 (mask 0x00010000) is high and all other bits are 0. An `rx_sof` with `rx_qual` low captures nothing.
- R5: While a path's enable bit is 0, that path makes no new capture, whatever its requests.
- R6: While a path's valid flag is set, further requests on that path are dropped. The held stamp does not change, and the per-packet status for a dropped packet is 0.
- R7: Reading a path's low stamp word returns stamp bits 31:0 and leaves the valid flag unchanged.
- R8: Reading a path's high stamp word returns stamp bits 63:32 and clears the valid flag at the same clock edge. The next qualifying packet is then captured.
- R9: Register map, with read data appearing one clock after `reg_rd`: address 0 is transmit control, 1 is transmit stamp low, 2 is transmit stamp high, 3 is receive control, 4 is receive stamp low, 5 is receive stamp high, and 6 and 7 read 0. In a control register bit 0 is valid (read-only) and bit 4 is the enable (read/write). All other bits read 0.
- R10: The two paths are independent. Captures, locks, enables and releases on one path never change the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_time | input | 64 | Current system time |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_cmd | input | 32 | Transmit descriptor command word; bit 19 requests a stamp |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_qual | input | 1 | Receive packet qualifies for a stamp (from the filter) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| tx_stamped | output | 1 | Pulse: the last transmit packet was stamped |
| rx_status | output | 32 | Receive descriptor status; bit 16 means stamped |

## Verification
Directed sequences cover the cases that single out one rule each. One is a request with the command bit clear against one with it set. Another is a second request arriving while a stamp is held, which shows the lock holds both the stamp and the status output. A low-word read followed by a high-word read shows that only the upper read re-arms the path. Disabled-path requests show the enable gates capture. A long random mix then interleaves strobes, qualifiers, enable writes and reads on both paths with random time values. This exposes any crosstalk between paths, and any wrong priority when a release and a new request land on the same edge.

// File: rtl/ts_capture_pkg.sv
package ts_capture_pkg;
  localparam int WORD_W = 32;
  localparam int TIME_W = 2 * WORD_W;
  localparam int NPATH  = 2;
  localparam int REGS_PER_PATH = 3;

  localparam int CTRL_VALID_BIT = 0;
  localparam int CTRL_EN_BIT    = 4;
  localparam int TX_REQ_BIT     = 19;
  localparam int RX_STAT_BIT    = 16;

  typedef enum logic [2:0] {
    SEL_TX_CTRL = 3'd0,
    SEL_TX_LO   = 3'd1,
    SEL_TX_HI   = 3'd2,
    SEL_RX_CTRL = 3'd3,
    SEL_RX_LO   = 3'd4,
    SEL_RX_HI   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/ts_path.sv
module ts_path #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              req,
  input  logic [TIME_W-1:0] cur_time,
  input  logic              en_we,
  input  logic              en_d,
  input  logic              release_rd,
  output logic              valid,
  output logic              en,
  output logic [TIME_W-1:0] stamp,
  output logic              stamped
);
  logic cap;
  assign cap = sof & req & en & ~valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      en      <= 1'b0;
      stamp   <= '0;
      stamped <= 1'b0;
    end else begin
      if (en_we) en <= en_d;
      stamped <= cap;
      if (cap) begin
        stamp <= cur_time;
        valid <= 1'b1;
      end else if (release_rd) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ts_regread.sv
module ts_regread
  import ts_capture_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd,
  input  logic [2:0]                  addr,
  input  logic [NPATH-1:0]            valid,
  input  logic [NPATH-1:0]            en,
  input  logic [NPATH-1:0][TIME_W-1:0] stamp,
  output logic [WORD_W-1:0]           rdata
);
  logic [WORD_W-1:0] mux;

  function automatic logic [WORD_W-1:0] ctrl_word(input logic v, input logic e);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CTRL_VALID_BIT] = v;
    w[CTRL_EN_BIT]    = e;
    return w;
  endfunction

  always_comb begin
    case (reg_sel_e'(addr))
      SEL_TX_CTRL: mux = ctrl_word(valid[0], en[0]);
      SEL_TX_LO:   mux = stamp[0][WORD_W-1:0];
      SEL_TX_HI:   mux = stamp[0][TIME_W-1:WORD_W];
      SEL_RX_CTRL: mux = ctrl_word(valid[1], en[1]);
      SEL_RX_LO:   mux = stamp[1][WORD_W-1:0];
      SEL_RX_HI:   mux = stamp[1][TIME_W-1:WORD_W];
      default:     mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= mux;
  end
endmodule

// File: rtl/ts_capture_latch.sv
module ts_capture_latch
  import ts_capture_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       cur_time,
  input  logic              tx_sof,
  input  logic [31:0]       tx_cmd,
  input  logic              rx_sof,
  input  logic              rx_qual,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_stamped,
  output logic [31:0]       rx_status
);
  logic [NPATH-1:0]             sof_v;
  logic [NPATH-1:0]             req_v;
  logic [NPATH-1:0]             valid_v;
  logic [NPATH-1:0]             en_v;
  logic [NPATH-1:0]             stamped_v;
  logic [NPATH-1:0][TIME_W-1:0] stamp_v;

  logic unused_in_bits;
  assign unused_in_bits = ^(tx_cmd & ~(32'h1 << TX_REQ_BIT)) ^
                          ^(reg_wdata & ~(32'h1 << CTRL_EN_BIT));

  assign sof_v = {rx_sof, tx_sof};
  assign req_v = {rx_qual, tx_cmd[TX_REQ_BIT]};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    localparam logic [2:0] CTRL_A = 3'(p * REGS_PER_PATH);
    localparam logic [2:0] HI_A   = 3'(p * REGS_PER_PATH + 2);
    ts_path #(.TIME_W(TIME_W)) u_path (
      .clk        (clk),
      .rst        (rst),
      .sof        (sof_v[p]),
      .req        (req_v[p]),
      .cur_time   (cur_time),
      .en_we      (reg_wr && reg_addr == CTRL_A),
      .en_d       (reg_wdata[CTRL_EN_BIT]),
      .release_rd (reg_rd && reg_addr == HI_A),
      .valid      (valid_v[p]),
      .en         (en_v[p]),
      .stamp      (stamp_v[p]),
      .stamped    (stamped_v[p])
    );
  end

  ts_regread u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd    (reg_rd),
    .addr  (reg_addr),
    .valid (valid_v),
    .en    (en_v),
    .stamp (stamp_v),
    .rdata (reg_rdata)
  );

  assign tx_stamped = stamped_v[0];
  always_comb begin
    rx_status = '0;
    rx_status[RX_STAT_BIT] = stamped_v[1];
  end
endmodule

// File: rtl/ts_capture_latch_chk.sv
module ts_capture_latch_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_rd,
  input logic [2:0]  reg_addr,
  input logic [1:0]  valid_v,
  input logic [1:0]  en_v,
  input logic [63:0] tx_stamp,
  input logic        tx_stamped,
  input logic [31:0] rx_status
);
  assert_status_new_R2: assert property (@(posedge clk) disable iff (rst)
    tx_stamped |-> (valid_v[0] && !$past(valid_v[0])));

  assert_rx_flag_R4: assert property (@(posedge clk) disable iff (rst)
    rx_status[16] |-> (valid_v[1] && !$past(valid_v[1])));

  assert_disabled_tx_R5: assert property (@(posedge clk) disable iff (rst)
    (!en_v[0] && !valid_v[0]) |=> !valid_v[0]);

  assert_disabled_rx_R5: assert property (@(posedge clk) disable iff (rst)
    (!en_v[1] && !valid_v[1]) |=> !valid_v[1]);

  assert_stamp_held_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_v[0] && !(reg_rd && reg_addr == 3'd2)) |=> (valid_v[0] && $stable(tx_stamp)));

  assert_low_read_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_v[0] && reg_rd && reg_addr == 3'd1) |=> valid_v[0]);

  assert_tx_release_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_v[0] && reg_rd && reg_addr == 3'd2) |=> !valid_v[0]);

  assert_rx_release_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_v[1] && reg_rd && reg_addr == 3'd5) |=> !valid_v[1]);
endmodule

bind ts_capture_latch ts_capture_latch_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .valid_v    (valid_v),
  .en_v       (en_v),
  .tx_stamp   (stamp_v[0]),
  .tx_stamped (tx_stamped),
  .rx_status  (rx_status)
);

// File: tb/ts_capture_latch_bench.sv
`timescale 1ns/1ps
module ts_capture_latch_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cur_time = '0;
  logic        tx_sof = 1'b0;
  logic [31:0] tx_cmd = '0;
  logic        rx_sof = 1'b0;
  logic        rx_qual = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_stamped;
  logic [31:0] rx_status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit          m_en [2];
  bit          m_val [2];
  logic [63:0] m_stamp [2];

  always #2.5 clk = ~clk;

  ts_capture_latch u_ts_capture_latch (
    .clk(clk), .rst(rst), .cur_time(cur_time), .tx_sof(tx_sof), .tx_cmd(tx_cmd),
    .rx_sof(rx_sof), .rx_qual(rx_qual), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_stamped(tx_stamped), .rx_status(rx_status)
  );

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {27'd0, m_en[0], 3'd0, m_val[0]};
      3'd1: return m_stamp[0][31:0];
      3'd2: return m_stamp[0][63:32];
      3'd3: return {27'd0, m_en[1], 3'd0, m_val[1]};
      3'd4: return m_stamp[1][31:0];
      3'd5: return m_stamp[1][63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // op: 0 none, 1 read, 2 write
  task automatic step(input string tag, input bit txs, input bit treq, input bit rxs,
                      input bit rxm, input int op, input logic [2:0] a,
                      input logic [31:0] wd, input logic [63:0] t);
    bit cap0, cap1, rel0, rel1;
    logic [31:0] exp_rd;
    tx_sof = txs; tx_cmd = treq ? 32'h0008_0000 : 32'h0000_0400;
    rx_sof = rxs; rx_qual = rxm; cur_time = t;
    reg_rd = (op == 1); reg_wr = (op == 2); reg_addr = a; reg_wdata = wd;
    cap0 = txs && treq && m_en[0] && !m_val[0];
    cap1 = rxs && rxm && m_en[1] && !m_val[1];
    rel0 = (op == 1) && a == 3'd2;
    rel1 = (op == 1) && a == 3'd5;
    exp_rd = model_read(a);
    @(posedge clk); #1;
    check(tag, "tx_stamped", {63'd0, tx_stamped}, {63'd0, cap0});
    check(tag, "rx_status", {32'd0, rx_status}, {32'd0, cap1 ? 32'h0001_0000 : 32'h0});
    if (op == 1) check(tag, "reg_rdata", {32'd0, reg_rdata}, {32'd0, exp_rd});
    if (cap0) begin m_val[0] = 1; m_stamp[0] = t; end else if (rel0) m_val[0] = 0;
    if (cap1) begin m_val[1] = 1; m_stamp[1] = t; end else if (rel1) m_val[1] = 0;
    if (op == 2 && a == 3'd0) m_en[0] = wd[4];
    if (op == 2 && a == 3'd3) m_en[1] = wd[4];
    tx_sof = 0; rx_sof = 0; reg_rd = 0; reg_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    step(tag, 0, 0, 0, 0, 1, a, 0, 64'h0);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [31:0] d);
    step(tag, 0, 0, 0, 0, 2, a, d, 64'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 2; i++) begin m_en[i] = 0; m_val[i] = 0; m_stamp[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1", "tx_stamped at reset", {63'd0, tx_stamped}, 64'd0);
    check("R1", "rx_status at reset", {32'd0, rx_status}, 64'd0);
    rd("R1", 3'd0);
    rd("R1", 3'd3);
    // R5: requests while disabled do nothing
    step("R5", 1, 1, 1, 1, 0, 0, 0, 64'h1111_2222_3333_4444);
    rd("R5", 3'd0);
    // R9: enable readback, unused addresses
    wr("R9", 3'd0, 32'hFFFF_FFFF);
    rd("R9", 3'd0);
    rd("R9", 3'd6);
    rd("R9", 3'd7);
    // R3: no request bit
    step("R3", 1, 0, 0, 0, 0, 0, 0, 64'hDEAD_BEEF_0000_0001);
    rd("R3", 3'd0);
    // R2: capture
    step("R2", 1, 1, 0, 0, 0, 0, 0, 64'hA5A5_0001_5A5A_0002);
    rd("R2", 3'd0);
    // R6: lock drops second request
    step("R6", 1, 1, 0, 0, 0, 0, 0, 64'h0BAD_0BAD_0BAD_0BAD);
    // R7: low read keeps valid
    rd("R7", 3'd1);
    rd("R7", 3'd0);
    // R8: high read releases, next capture works
    rd("R8", 3'd2);
    rd("R8", 3'd0);
    step("R8", 1, 1, 0, 0, 0, 0, 0, 64'h7777_8888_9999_AAAA);
    rd("R8", 3'd1);
    // R4: receive path
    wr("R4", 3'd3, 32'h0000_0010);
    step("R4", 0, 0, 1, 0, 0, 0, 0, 64'h1);
    step("R4", 0, 0, 1, 1, 0, 0, 0, 64'hCAFE_F00D_1234_5678);
    rd("R4", 3'd4);
    rd("R4", 3'd5);
    // R10: tx still holds its stamp independent of rx activity
    rd("R10", 3'd2);
    rd("R10", 3'd3);
    // R5: disable tx, request ignored
    wr("R5", 3'd0, 32'h0);
    step("R5", 1, 1, 0, 0, 0, 0, 0, 64'h5555_5555_5555_5555);
    rd("R5", 3'd0);
    // R8/R6: release and new request on same edge (valid clear: capture wins on rx)
    rd("R8", 3'd5);
    step("R8", 0, 0, 1, 1, 1, 3'd5, 0, 64'h0102_0304_0506_0708);
    rd("R8", 3'd4);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [2:0] a;
      int k;
      k = $urandom % 10;
      if (k < 5) begin op = 0; a = 3'($urandom % 8); end
      else if (k < 9) begin op = 1; a = 3'($urandom % 8); end
      else begin op = 2; a = ($urandom % 2) ? 3'd3 : 3'd0; end
      step("R10", ($urandom % 3) == 0, $urandom % 2, ($urandom % 3) == 0, $urandom % 2,
           op, a, (($urandom % 4) != 0) ? 32'h10 : 32'h0, {$urandom, $urandom});
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule